// File: doc/BRIEF.md
# PWM Event Synchronization and Interrupt Unit

This block sits next to a two-channel PWM waveform generator. It takes the generator's per-cycle event strobes (compare matches that set and reset each part, fault and retrigger strobes for each part, a counter-capture strobe and a synchronization-error strobe) and derives three kinds of output from them.

The first output is a one-clock ADC trigger. A 2-bit code picks the leading or trailing edge of one of the two PWM outputs as its source. The second is a set of three sticky interrupt flags: end of cycle, end of enhanced cycle, and capture. Each flag has its own enable and its own write-one-to-clear strobe. The third is a selectable routing of waveforms A and B onto two output pins.

The configuration lives in a 7-bit register. It is loaded by a write strobe and resets to zero. The PWM counter itself lies outside this block.

Top module: `pwm_evt_sync`

## Requirements
- R1: After reset all configuration bits are 0. The trigger code is then 00, both pin selects are 0, all enables are 0, and all flags are 0.
- R2: The configuration register is written when `cfg_we` is 1 and takes effect from the next cycle. The bit layout is: bits 1:0 trigger code, bit 2 pin22 select, bit 3 pin23 select, bit 4 end-of-cycle enable, bit 5 enhanced-cycle enable, bit 6 capture enable.
- R3: With code 00, `adc_sync` is high in the same cycle as `set_a`. With code 10, it is high in the same cycle as `set_b`.
- R4: With code 01, `adc_sync` is high in the same cycle as any of `rst_a`, `fault_a` or `retrig_a`. With code 11, it is high with any of `rst_b`, `fault_b` or `retrig_b`.
- R5: `adc_sync` stays low in any cycle where no strobe of the selected source is high, whatever the other strobes do.
- R6: When the end-of-cycle enable is 1, a `rst_b` strobe sets `irq_flag[0]` one cycle later. When the enable is 0, the flag stays 0.
- R7: The block counts `rst_b` strobes in a 4-bit counter that is cleared by reset. The strobe that finds the counter at 15 sets `irq_flag[1]` one cycle later, if its enable is 1, and wraps the counter to 0. This means every 16th strobe since reset sets the flag.
- R8: When the capture enable is 1, any of `retrig_a`, `retrig_b`, `capt_evt` or `sync_err` sets `irq_flag[2]` one cycle later.
- R9: A flag stays at 1 until its `irq_clr` bit is pulsed. The flag reads 0 on the cycle after that pulse. If a set event and a clear pulse arrive in the same cycle, the flag stays 1.
- R10: `pin22` carries `wave_a` when its select is 0 and `wave_b` when its select is 1. The output is registered, so it follows the inputs one cycle later.
- R11: `pin23` carries `wave_b` when its select is 0 and `wave_a` when its select is 1. The output is registered, so it follows the inputs one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration write data |
| set_a | input | 1 | Compare match that sets part A |
| rst_a | input | 1 | Compare match that resets part A |
| set_b | input | 1 | Compare match that sets part B |
| rst_b | input | 1 | Compare match that resets part B (end of cycle) |
| fault_a | input | 1 | Fault strobe, part A |
| fault_b | input | 1 | Fault strobe, part B |
| retrig_a | input | 1 | Retrigger strobe, part A |
| retrig_b | input | 1 | Retrigger strobe, part B |
| capt_evt | input | 1 | Counter capture strobe |
| sync_err | input | 1 | Synchronization error strobe |
| wave_a | input | 1 | Waveform A |
| wave_b | input | 1 | Waveform B |
| irq_clr | input | 3 | Write-one-to-clear strobes for the flags |
| adc_sync | output | 1 | One-clock ADC trigger |
| irq_flag | output | 3 | Flags: bit 0 end of cycle, bit 1 enhanced cycle, bit 2 capture |
| pin22 | output | 1 | Routed output 22 |
| pin23 | output | 1 | Routed output 23 |

## Verification
A corrupted configuration register shows at once, because `adc_sync` is combinational from the strobes and the stored code, and the routed pins follow one cycle later. A flag state or counter state that is off by one shows only at the enhanced-cycle flag, and it can take up to sixteen `rst_b` strobes to surface. For that reason the bench counts strobes from reset and checks the flag both at the 15th strobe and at the 16th, in two successive rounds, so that the wrap is checked too. A flag that drops without a clear, or that survives a clear, shows on the very next cycle.

// File: rtl/pes_pkg.sv
package pes_pkg;
  localparam int NFLAG     = 3;
  localparam int FLAG_EC   = 0;
  localparam int FLAG_EEC  = 1;
  localparam int FLAG_CAPT = 2;

  typedef struct packed {
    logic       capt_en;
    logic       eec_en;
    logic       ec_en;
    logic       sel23;
    logic       sel22;
    logic [1:0] sync_sel;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/pes_adc_trig.sv
module pes_adc_trig (
  input  logic [1:0] sync_sel,
  input  logic       set_a,
  input  logic       rst_a,
  input  logic       set_b,
  input  logic       rst_b,
  input  logic       fault_a,
  input  logic       fault_b,
  input  logic       retrig_a,
  input  logic       retrig_b,
  output logic       adc_sync
);
  logic [3:0] src;

  always_comb begin
    src[0] = set_a;
    src[1] = rst_a | fault_a | retrig_a;
    src[2] = set_b;
    src[3] = rst_b | fault_b | retrig_b;
    adc_sync = src[sync_sel];
  end
endmodule

// File: rtl/pes_enh_cnt.sv
module pes_enh_cnt #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic last_hit
);
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign last_hit = adv && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (adv)
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pes_irq_flags.sv
module pes_irq_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_vec,
  input  logic [NF-1:0] clr_vec,
  output logic [NF-1:0] flag_q
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flag_q[i] <= 1'b0;
      else if (set_vec[i])
        flag_q[i] <= 1'b1;
      else if (clr_vec[i])
        flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/pes_out_route.sv
module pes_out_route (
  input  logic clk,
  input  logic rst,
  input  logic sel22,
  input  logic sel23,
  input  logic wave_a,
  input  logic wave_b,
  output logic pin22,
  output logic pin23
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin22 <= 1'b0;
      pin23 <= 1'b0;
    end else begin
      pin22 <= sel22 ? wave_b : wave_a;
      pin23 <= sel23 ? wave_a : wave_b;
    end
  end
endmodule

// File: rtl/pwm_evt_sync.sv
module pwm_evt_sync
  import pes_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             set_a,
  input  logic             rst_a,
  input  logic             set_b,
  input  logic             rst_b,
  input  logic             fault_a,
  input  logic             fault_b,
  input  logic             retrig_a,
  input  logic             retrig_b,
  input  logic             capt_evt,
  input  logic             sync_err,
  input  logic             wave_a,
  input  logic             wave_b,
  input  logic [NFLAG-1:0] irq_clr,
  output logic             adc_sync,
  output logic [NFLAG-1:0] irq_flag,
  output logic             pin22,
  output logic             pin23
);
  cfg_t             cfg_q;
  logic             enh_last;
  logic [NFLAG-1:0] flag_set;

  always_ff @(posedge clk) begin
    if (rst)
      cfg_q <= '0;
    else if (cfg_we)
      cfg_q <= cfg_t'(cfg_wdata);
  end

  pes_adc_trig trig_i (
    .sync_sel (cfg_q.sync_sel),
    .set_a    (set_a),
    .rst_a    (rst_a),
    .set_b    (set_b),
    .rst_b    (rst_b),
    .fault_a  (fault_a),
    .fault_b  (fault_b),
    .retrig_a (retrig_a),
    .retrig_b (retrig_b),
    .adc_sync (adc_sync)
  );

  pes_enh_cnt #(.CNT_W(CNT_W)) enh_i (
    .clk      (clk),
    .rst      (rst),
    .adv      (rst_b),
    .last_hit (enh_last)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_EC]   = cfg_q.ec_en & rst_b;
    flag_set[FLAG_EEC]  = cfg_q.eec_en & enh_last;
    flag_set[FLAG_CAPT] = cfg_q.capt_en & (retrig_a | retrig_b | capt_evt | sync_err);
  end

  pes_irq_flags #(.NF(NFLAG)) flags_i (
    .clk     (clk),
    .rst     (rst),
    .set_vec (flag_set),
    .clr_vec (irq_clr),
    .flag_q  (irq_flag)
  );

  pes_out_route route_i (
    .clk    (clk),
    .rst    (rst),
    .sel22  (cfg_q.sel22),
    .sel23  (cfg_q.sel23),
    .wave_a (wave_a),
    .wave_b (wave_b),
    .pin22  (pin22),
    .pin23  (pin23)
  );
endmodule

// File: rtl/pes_evt_checker.sv
module pes_evt_checker
  import pes_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input cfg_t             cfg_q,
  input logic             set_a,
  input logic             rst_a,
  input logic             set_b,
  input logic             rst_b,
  input logic             fault_a,
  input logic             fault_b,
  input logic             retrig_a,
  input logic             retrig_b,
  input logic             capt_evt,
  input logic             sync_err,
  input logic             wave_a,
  input logic             wave_b,
  input logic [NFLAG-1:0] irq_clr,
  input logic             adc_sync,
  input logic [NFLAG-1:0] irq_flag,
  input logic             pin22,
  input logic             pin23
);
  a_r3_lead_a: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.sync_sel == 2'b00 && set_a) |-> adc_sync);

  a_r4_trail_b: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.sync_sel == 2'b11 && (rst_b || fault_b || retrig_b)) |-> adc_sync);

  a_r5_no_source: assert property (@(posedge clk) disable iff (rst)
    adc_sync |-> (set_a || rst_a || set_b || rst_b || fault_a || fault_b || retrig_a || retrig_b));

  a_r6_ec_set: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.ec_en && rst_b) |=> irq_flag[FLAG_EC]);

  a_r7_eec_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag[FLAG_EEC]) |-> $past(rst_b));

  a_r8_capt_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag[FLAG_CAPT]) |-> $past(retrig_a || retrig_b || capt_evt || sync_err));

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_flag[FLAG_CAPT] && !irq_clr[FLAG_CAPT]) |=> irq_flag[FLAG_CAPT]);

  a_r10_pin22: assert property (@(posedge clk) disable iff (rst)
    !cfg_q.sel22 |=> pin22 == $past(wave_a));

  a_r11_pin23: assert property (@(posedge clk) disable iff (rst)
    !cfg_q.sel23 |=> pin23 == $past(wave_b));
endmodule

bind pwm_evt_sync pes_evt_checker chk_i (
  .clk(clk), .rst(rst), .cfg_q(cfg_q),
  .set_a(set_a), .rst_a(rst_a), .set_b(set_b), .rst_b(rst_b),
  .fault_a(fault_a), .fault_b(fault_b), .retrig_a(retrig_a), .retrig_b(retrig_b),
  .capt_evt(capt_evt), .sync_err(sync_err), .wave_a(wave_a), .wave_b(wave_b),
  .irq_clr(irq_clr), .adc_sync(adc_sync), .irq_flag(irq_flag),
  .pin22(pin22), .pin23(pin23)
);

// File: tb/pwm_evt_sync_tb_top.sv
`timescale 1ns/1ps
module pwm_evt_sync_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic set_a = 0, rst_a = 0, set_b = 0, rst_b = 0;
  logic fault_a = 0, fault_b = 0, retrig_a = 0, retrig_b = 0;
  logic capt_evt = 0, sync_err = 0, wave_a = 0, wave_b = 0;
  logic [2:0] irq_clr = '0;
  logic adc_sync;
  logic [2:0] irq_flag;
  logic pin22, pin23;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pwm_evt_sync dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .set_a(set_a), .rst_a(rst_a), .set_b(set_b), .rst_b(rst_b),
    .fault_a(fault_a), .fault_b(fault_b), .retrig_a(retrig_a), .retrig_b(retrig_b),
    .capt_evt(capt_evt), .sync_err(sync_err), .wave_a(wave_a), .wave_b(wave_b),
    .irq_clr(irq_clr), .adc_sync(adc_sync), .irq_flag(irq_flag),
    .pin22(pin22), .pin23(pin23)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wcfg(input logic [6:0] v);
    cfg_we = 1'b1;
    cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic strobes(input logic [7:0] p);
    {retrig_b, retrig_a, fault_b, fault_a, rst_b, set_b, rst_a, set_a} = p;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic pulse_rstb();
    rst_b = 1'b1;
    tick();
    rst_b = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic exp_adc;
    do_reset();

    // R1: reset state; code 00 means set_a drives the trigger
    chk("R1 flags", {1'b0, irq_flag}, 4'h0);
    wave_a = 1'b1; wave_b = 1'b0;
    tick();
    chk("R1 routing", {2'b00, pin23, pin22}, 4'b0001);
    set_a = 1'b1; #1;
    chk("R1 code00", {3'b0, adc_sync}, 4'h1);
    tick(); set_a = 1'b0;
    chk("R1 no flag", {1'b0, irq_flag}, 4'h0);

    // R2 R3 R4 R5: sweep all codes against all strobe patterns
    for (int sel = 0; sel < 4; sel++) begin
      wcfg(7'(sel));
      for (int p = 0; p < 256; p++) begin
        strobes(8'(p));
        #1;
        case (sel)
          0: exp_adc = p[0];
          1: exp_adc = p[1] | p[4] | p[6];
          2: exp_adc = p[2];
          default: exp_adc = p[3] | p[5] | p[7];
        endcase
        if (sel[0]) chk("R4 trailing", {3'b0, adc_sync}, {3'b0, exp_adc});
        else if (exp_adc) chk("R3 leading", {3'b0, adc_sync}, 4'h1);
        else chk("R5 quiet", {3'b0, adc_sync}, 4'h0);
        tick();
      end
      strobes(8'h00);
    end
    chk("R2 enables off no flags", {1'b0, irq_flag}, 4'h0);

    // R10 R11: routing sweep
    for (int s = 0; s < 4; s++) begin
      wcfg(7'(s << 2));
      for (int w = 0; w < 4; w++) begin
        wave_a = w[0]; wave_b = w[1];
        tick();
        chk("R10 pin22", {3'b0, pin22}, {3'b0, (s[0] ? w[1] : w[0])});
        chk("R11 pin23", {3'b0, pin23}, {3'b0, (s[1] ? w[0] : w[1])});
      end
    end

    // R6: end-of-cycle flag, disabled and enabled
    wcfg(7'h00);
    pulse_rstb();
    chk("R6 disabled", {3'b0, irq_flag[0]}, 4'h0);
    wcfg(7'h10);
    pulse_rstb();
    chk("R6 set", {3'b0, irq_flag[0]}, 4'h1);
    // R9: sticky, clear, set wins
    tick(); tick();
    chk("R9 sticky", {3'b0, irq_flag[0]}, 4'h1);
    irq_clr = 3'b001; tick(); irq_clr = '0;
    chk("R9 cleared", {3'b0, irq_flag[0]}, 4'h0);
    pulse_rstb();
    irq_clr = 3'b001; rst_b = 1'b1; tick(); irq_clr = '0; rst_b = 1'b0;
    chk("R9 set wins", {3'b0, irq_flag[0]}, 4'h1);
    irq_clr = 3'b001; tick(); irq_clr = '0;

    // R8: capture sources each on their own
    wcfg(7'h40);
    for (int k = 0; k < 4; k++) begin
      {sync_err, capt_evt, retrig_b, retrig_a} = 4'(1 << k);
      tick();
      {sync_err, capt_evt, retrig_b, retrig_a} = 4'h0;
      chk("R8 capture", {3'b0, irq_flag[2]}, 4'h1);
      irq_clr = 3'b100; tick(); irq_clr = '0;
      chk("R9 capture clear", {3'b0, irq_flag[2]}, 4'h0);
    end
    wcfg(7'h00);
    capt_evt = 1'b1; tick(); capt_evt = 1'b0;
    chk("R8 disabled", {3'b0, irq_flag[2]}, 4'h0);

    // R7: every 16th rst_b strobe since reset, two rounds
    do_reset();
    wcfg(7'h20);
    for (int r = 0; r < 2; r++) begin
      for (int n = 1; n <= 15; n++) pulse_rstb();
      chk("R7 before 16th", {3'b0, irq_flag[1]}, 4'h0);
      pulse_rstb();
      chk("R7 at 16th", {3'b0, irq_flag[1]}, 4'h1);
      chk("R7 ec off", {3'b0, irq_flag[0]}, 4'h0);
      irq_clr = 3'b010; tick(); irq_clr = '0;
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule